// File: doc/BRIEF.md
# Receive Link-Rate Reconfiguration Sequencer

This block is the control state machine that keeps a multi-rate serial video receiver tuned to the rate of the link it is fed. After coming out of reset, it holds the receive PLL and the receive transceiver in reset. It then starts an external rate detector. That detector returns a frequency band code and a colour depth, together with hints on which of the two analog blocks the new setting touches. When the returned pair differs from the setting last applied, the sequencer raises a reconfiguration request to the PLL, the transceiver, or both. It waits until every raised request reports completion. It then pulses the resets again.

Once the receiver is running, the sequencer waits a programmable interval and measures the rate again. It restarts the whole sequence when the new measurement no longer matches the applied setting, or when the PLL, the transceiver or the downstream video core drops its lock indication. A band match alone is not enough to skip reconfiguration, because several colour depths share one band. The register writes behind each request and the rate measurement circuit are outside this block.

Top module: `rx_rate_reconfig_seq`

## Requirements
- R1: After synchronous reset is released, `rx_pll_rst` and `rx_xcvr_rst` are both high for exactly RST_CYCLES clock samples, counting the last sample taken while reset was still being released. During that time `meas_start` and both requests stay low.
- R2: When the first reset pulse ends, `meas_start` is high for exactly one cycle. The sequencer then waits for `meas_valid`.
- R3: The first measurement after power-up always leads to reconfiguration, whatever band and depth it carries, because the applied setting starts out invalid.
- R4: A measurement equal in both band and depth to the applied setting raises no request. On the start-up path it goes straight to the second reset. On the monitoring path it returns to the interval wait, and the next `meas_start` follows MON_INTERVAL cycles later with no reset.
- R5: A measurement with the same band but a different colour depth is treated as a change and leads to reconfiguration.
- R6: `pll_cfg_req` is raised when `meas_pll_sel` is 1, and `xcvr_cfg_req` is raised when `meas_xcvr_sel` is 1. If both select bits are 0, both requests are raised. Each request stays high until its own done input is seen. The sequencer leaves the configuration phase only when every raised request has dropped. The resets stay low throughout this phase.
- R7: After reconfiguration, or after a skipped one, both resets are high again for RST_CYCLES cycles. Then MON_INTERVAL cycles pass with `meas_start` low before the next single-cycle `meas_start`.
- R8: A monitoring measurement whose band or depth differs from the applied setting restarts the sequence. The resets are high in the cycle after `meas_valid`, and the following measurement is compared again and reconfigures.
- R9: While monitoring, a low level on any of `pll_locked`, `xcvr_locked` or `core_locked` restarts the sequence. The resets are high in the next cycle.
- R10: Lock inputs are ignored from the start-up measurement until the monitoring interval begins. A lock drop during the configuration phase changes neither the requests nor the resets.
- R11: While a request is high, `cfg_band` and `cfg_depth` show the band and depth of the measurement that caused it, and they stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pll_rst | output | 1 | Reset to the receive PLL |
| rx_xcvr_rst | output | 1 | Reset to the receive transceiver |
| meas_start | output | 1 | One-cycle start pulse to the rate detector |
| meas_valid | input | 1 | Rate detector result is valid this cycle |
| meas_band | input | BAND_W | Measured frequency band code |
| meas_depth | input | DEPTH_W | Measured colour depth code |
| meas_pll_sel | input | 1 | New setting needs PLL reprogramming |
| meas_xcvr_sel | input | 1 | New setting needs transceiver reprogramming |
| pll_cfg_req | output | 1 | PLL reconfiguration request, held until done |
| pll_cfg_done | input | 1 | PLL reconfiguration and recalibration finished |
| xcvr_cfg_req | output | 1 | Transceiver reconfiguration request, held until done |
| xcvr_cfg_done | input | 1 | Transceiver reconfiguration and recalibration finished |
| cfg_band | output | BAND_W | Band of the setting being applied |
| cfg_depth | output | DEPTH_W | Colour depth of the setting being applied |
| pll_locked | input | 1 | Receive PLL lock |
| xcvr_locked | input | 1 | Transceiver lock |
| core_locked | input | 1 | Downstream video core lock |

## Verification
The hardest states to reach from the ports are on the monitoring path. A depth-only change, or a lock drop, must happen after the monitoring interval has started, while a lock drop during configuration must have no effect. The bench answers every `meas_start` in the cycle after the pulse with a chosen band, depth and select pair. It uses a short monitoring interval, so it can walk the sequencer from start-up into monitoring and then cause each restart cause in turn. In each case the bench sees the restart as a reset pulse of known length, followed by a fresh comparison against the setting last applied.

// File: rtl/rxrc_pkg.sv
package rxrc_pkg;

    parameter int BAND_W  = 3;
    parameter int DEPTH_W = 2;
    parameter int N_SLOTS = 2;   // slot 0: PLL, slot 1: transceiver

    typedef enum logic [2:0] {
        ST_RST_PRE,
        ST_MEAS_GO,
        ST_MEAS_WAIT,
        ST_CFG,
        ST_RST_POST,
        ST_MON_WAIT
    } rxrc_state_e;

    typedef struct packed {
        logic [BAND_W-1:0]  band;
        logic [DEPTH_W-1:0] depth;
    } rx_cfg_t;

    function automatic logic cfg_differs(rx_cfg_t fresh, rx_cfg_t held, logic held_ok);
        return !held_ok || (fresh.band != held.band) || (fresh.depth != held.depth);
    endfunction

    function automatic logic [N_SLOTS-1:0] slot_select(logic pll_sel, logic xcvr_sel);
        logic [N_SLOTS-1:0] s;
        s = '0;
        if (!pll_sel && !xcvr_sel) begin
            s = '1;
        end else begin
            s[0] = pll_sel;
            s[1] = xcvr_sel;
        end
        return s;
    endfunction

endpackage

// File: rtl/rxrc_cycle_counter.sv
module rxrc_cycle_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic last
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST_VAL = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && cnt != LAST_VAL) begin
            cnt <= cnt + W'(1);
        end
    end

    assign last = (cnt == LAST_VAL);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_VAL); // R7
endmodule

// File: rtl/rxrc_setting_track.sv
module rxrc_setting_track
    import rxrc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  rx_cfg_t meas,
    output rx_cfg_t applied,
    output logic    differ
);
    logic held_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_ok <= 1'b0;
            applied <= '1;
        end else if (load) begin
            held_ok <= 1'b1;
            applied <= meas;
        end
    end

    assign differ = cfg_differs(meas, applied, held_ok);

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> (applied == $past(meas))); // R11
endmodule

// File: rtl/rxrc_req_slot.sv
module rxrc_req_slot (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic done,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else if (set) begin
            req <= 1'b1;
        end else if (req && done) begin
            req <= 1'b0;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req && !done) |=> req); // R6
endmodule

// File: rtl/rx_rate_reconfig_seq.sv
module rx_rate_reconfig_seq
    import rxrc_pkg::*;
#(
    parameter int RST_CYCLES   = 16,
    parameter int MON_INTERVAL = 1 << 20
) (
    input  logic               clk,
    input  logic               rst,
    output logic               rx_pll_rst,
    output logic               rx_xcvr_rst,
    output logic               meas_start,
    input  logic               meas_valid,
    input  logic [BAND_W-1:0]  meas_band,
    input  logic [DEPTH_W-1:0] meas_depth,
    input  logic               meas_pll_sel,
    input  logic               meas_xcvr_sel,
    output logic               pll_cfg_req,
    input  logic               pll_cfg_done,
    output logic               xcvr_cfg_req,
    input  logic               xcvr_cfg_done,
    output logic [BAND_W-1:0]  cfg_band,
    output logic [DEPTH_W-1:0] cfg_depth,
    input  logic               pll_locked,
    input  logic               xcvr_locked,
    input  logic               core_locked
);
    rxrc_state_e state, state_nx;
    logic        monitoring;
    logic        lock_lost;
    logic        rst_last, mon_last;
    logic        differ, load;
    rx_cfg_t     meas_cfg, applied;
    logic [N_SLOTS-1:0] slot_set, slot_done, slot_req;

    assign lock_lost = !(pll_locked && xcvr_locked && core_locked);
    assign meas_cfg  = '{band: meas_band, depth: meas_depth};

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RST_PRE:   if (rst_last) state_nx = ST_MEAS_GO;
            ST_MEAS_GO:   state_nx = ST_MEAS_WAIT;
            ST_MEAS_WAIT: begin
                if (monitoring && lock_lost) begin
                    state_nx = ST_RST_PRE;
                end else if (meas_valid) begin
                    if (monitoring) state_nx = differ ? ST_RST_PRE : ST_MON_WAIT;
                    else            state_nx = differ ? ST_CFG : ST_RST_POST;
                end
            end
            ST_CFG:       if (slot_req == '0) state_nx = ST_RST_POST;
            ST_RST_POST:  if (rst_last) state_nx = ST_MON_WAIT;
            ST_MON_WAIT: begin
                if (lock_lost)     state_nx = ST_RST_PRE;
                else if (mon_last) state_nx = ST_MEAS_GO;
            end
            default:      state_nx = ST_RST_PRE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RST_PRE;
            monitoring <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_MON_WAIT && state_nx == ST_MEAS_GO) begin
                monitoring <= 1'b1;
            end else if (state_nx == ST_RST_PRE || (state == ST_MEAS_WAIT && state_nx != ST_MEAS_WAIT)) begin
                monitoring <= 1'b0;
            end
        end
    end

    rxrc_cycle_counter #(.LIMIT(RST_CYCLES)) i_rst_cnt (
        .clk (clk),
        .rst (rst),
        .clr (state_nx != state),
        .en  (state == ST_RST_PRE || state == ST_RST_POST),
        .last(rst_last)
    );

    rxrc_cycle_counter #(.LIMIT(MON_INTERVAL)) i_mon_cnt (
        .clk (clk),
        .rst (rst),
        .clr (state_nx != state),
        .en  (state == ST_MON_WAIT),
        .last(mon_last)
    );

    assign load = (state == ST_MEAS_WAIT) && meas_valid && !monitoring && differ;

    rxrc_setting_track i_track (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .meas   (meas_cfg),
        .applied(applied),
        .differ (differ)
    );

    assign slot_set  = load ? slot_select(meas_pll_sel, meas_xcvr_sel) : '0;
    assign slot_done = {xcvr_cfg_done, pll_cfg_done};

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        rxrc_req_slot i_slot (
            .clk (clk),
            .rst (rst),
            .set (slot_set[g]),
            .done(slot_done[g]),
            .req (slot_req[g])
        );
    end

    assign pll_cfg_req  = slot_req[0];
    assign xcvr_cfg_req = slot_req[1];
    assign rx_pll_rst   = (state == ST_RST_PRE) || (state == ST_RST_POST);
    assign rx_xcvr_rst  = rx_pll_rst;
    assign meas_start   = (state == ST_MEAS_GO);
    assign cfg_band     = applied.band;
    assign cfg_depth    = applied.depth;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        meas_start |=> !meas_start); // R2
    AST_REQ_NOT_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        (pll_cfg_req || xcvr_cfg_req) |-> (!rx_pll_rst && !meas_start)); // R6
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
        ((pll_cfg_req || xcvr_cfg_req) && $past(pll_cfg_req || xcvr_cfg_req))
        |-> ($stable(cfg_band) && $stable(cfg_depth))); // R11
    AST_LOCK_IGNORED_IN_CFG: assert property (@(posedge clk) disable iff (rst)
        (pll_cfg_req || xcvr_cfg_req) |=> !meas_start); // R10
endmodule

// File: tb/test_rx_rate_reconfig_seq.sv
module test_rx_rate_reconfig_seq;
    localparam int RSTC = 4;
    localparam int MONI = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_pll_rst, rx_xcvr_rst, meas_start;
    logic       meas_valid = 1'b0;
    logic [2:0] meas_band = '0;
    logic [1:0] meas_depth = '0;
    logic       meas_pll_sel = 1'b0, meas_xcvr_sel = 1'b0;
    logic       pll_cfg_req, xcvr_cfg_req;
    logic       pll_cfg_done = 1'b0, xcvr_cfg_done = 1'b0;
    logic [2:0] cfg_band;
    logic [1:0] cfg_depth;
    logic       pll_locked = 1'b1, xcvr_locked = 1'b1, core_locked = 1'b1;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    rx_rate_reconfig_seq #(.RST_CYCLES(RSTC), .MON_INTERVAL(MONI)) i_rx_rate_reconfig_seq (
        .clk(clk), .rst(rst),
        .rx_pll_rst(rx_pll_rst), .rx_xcvr_rst(rx_xcvr_rst), .meas_start(meas_start),
        .meas_valid(meas_valid), .meas_band(meas_band), .meas_depth(meas_depth),
        .meas_pll_sel(meas_pll_sel), .meas_xcvr_sel(meas_xcvr_sel),
        .pll_cfg_req(pll_cfg_req), .pll_cfg_done(pll_cfg_done),
        .xcvr_cfg_req(xcvr_cfg_req), .xcvr_cfg_done(xcvr_cfg_done),
        .cfg_band(cfg_band), .cfg_depth(cfg_depth),
        .pll_locked(pll_locked), .xcvr_locked(xcvr_locked), .core_locked(core_locked)
    );

    task automatic chk(input string rq, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Counts samples with both resets high, starting at the first high sample.
    task automatic rst_pulse(input string rq);
        int n = 0;
        int guard = 0;
        int mism = 0;
        while (!rx_pll_rst && guard < 1000) begin @(negedge clk); guard++; end
        while (rx_pll_rst && n < 1000) begin
            if (rx_xcvr_rst !== 1'b1) mism++;
            n++;
            @(negedge clk);
        end
        chk({rq, " reset pulse length"}, n, RSTC);
        chk({rq, " resets equal"}, mism, 0);
    endtask

    // Counts samples with meas_start low, the current one included; stops on meas_start.
    task automatic wait_start(output int n);
        n = 0;
        while (!meas_start && n < 10000) begin n++; @(negedge clk); end
    endtask

    // Called at a sample with meas_start high; returns one sample after the result was accepted.
    task automatic feed(input logic [2:0] b, input logic [1:0] d, input logic ps, input logic xs);
        @(negedge clk);
        chk("R2 start single cycle", int'(meas_start), 0);
        meas_band = b; meas_depth = d; meas_pll_sel = ps; meas_xcvr_sel = xs;
        meas_valid = 1'b1;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(negedge clk);
        chk("R1 pll reset during rst", int'(rx_pll_rst), 1);
        chk("R1 xcvr reset during rst", int'(rx_xcvr_rst), 1);
        chk("R1 no start during rst", int'(meas_start), 0);
        chk("R1 no req during rst", int'(pll_cfg_req | xcvr_cfg_req), 0);
        rst = 1'b0;
        rst_pulse("R1");
        wait_start(n);
        chk("R2 start right after reset", n, 0);
    endtask

    task automatic t_first();
        int n;
        feed(3'd3, 2'd1, 1'b0, 1'b0);
        chk("R3 first pll req", int'(pll_cfg_req), 1);
        chk("R6 no select gives both", int'(xcvr_cfg_req), 1);
        chk("R11 cfg band", int'(cfg_band), 3);
        chk("R11 cfg depth", int'(cfg_depth), 1);
        pll_locked = 1'b0; xcvr_locked = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reqs kept on lock drop", int'({pll_cfg_req, xcvr_cfg_req}), 3);
        chk("R10 no reset on lock drop", int'(rx_pll_rst), 0);
        pll_cfg_done = 1'b1;
        @(negedge clk);
        pll_cfg_done = 1'b0;
        chk("R6 pll req cleared", int'(pll_cfg_req), 0);
        chk("R6 xcvr req held", int'(xcvr_cfg_req), 1);
        chk("R6 waits for all done", int'(rx_pll_rst), 0);
        pll_locked = 1'b1; xcvr_locked = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 still waiting", int'(rx_pll_rst), 0);
        xcvr_cfg_done = 1'b1;
        @(negedge clk);
        xcvr_cfg_done = 1'b0;
        rst_pulse("R7");
        wait_start(n);
        chk("R7 monitor interval", n, MONI);
    endtask

    task automatic t_same();
        int n;
        feed(3'd3, 2'd1, 1'b0, 1'b0);
        chk("R4 no req on match", int'(pll_cfg_req | xcvr_cfg_req), 0);
        chk("R4 no reset on match", int'(rx_pll_rst), 0);
        wait_start(n);
        chk("R4 next monitor start", n, MONI);
    endtask

    task automatic t_depth();
        int n;
        feed(3'd3, 2'd2, 1'b1, 1'b0);
        chk("R8 restart on depth change", int'(rx_pll_rst), 1);
        rst_pulse("R8");
        wait_start(n);
        chk("R8 measure after restart", n, 0);
        feed(3'd3, 2'd2, 1'b1, 1'b0);
        chk("R5 depth change reconfigures", int'(pll_cfg_req), 1);
        chk("R6 pll only select", int'(xcvr_cfg_req), 0);
        chk("R11 new depth shown", int'(cfg_depth), 2);
        pll_cfg_done = 1'b1;
        @(negedge clk);
        pll_cfg_done = 1'b0;
        rst_pulse("R7 after depth cfg");
        wait_start(n);
        chk("R7 interval after depth cfg", n, MONI);
    endtask

    task automatic t_lock();
        int n;
        feed(3'd3, 2'd2, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R9 no reset before drop", int'(rx_pll_rst), 0);
        core_locked = 1'b0;
        @(negedge clk);
        chk("R9 restart on lock loss", int'(rx_pll_rst), 1);
        core_locked = 1'b1;
        rst_pulse("R9");
        wait_start(n);
        chk("R9 measure after restart", n, 0);
        feed(3'd3, 2'd2, 1'b0, 1'b1);
        chk("R4 startup match no req", int'(pll_cfg_req | xcvr_cfg_req), 0);
        chk("R4 startup match post reset", int'(rx_pll_rst), 1);
        rst_pulse("R4");
        wait_start(n);
        chk("R4 interval after skip", n, MONI);
    endtask

    task automatic t_band();
        int n;
        feed(3'd5, 2'd2, 1'b0, 1'b1);
        chk("R8 restart on band change", int'(rx_pll_rst), 1);
        rst_pulse("R8 band");
        wait_start(n);
        feed(3'd5, 2'd2, 1'b0, 1'b1);
        chk("R6 xcvr only select", int'({pll_cfg_req, xcvr_cfg_req}), 1);
        chk("R11 new band shown", int'(cfg_band), 5);
        xcvr_cfg_done = 1'b1;
        @(negedge clk);
        xcvr_cfg_done = 1'b0;
        rst_pulse("R7 after band cfg");
    endtask

    initial begin
        t_reset();
        t_first();
        t_same();
        t_depth();
        t_lock();
        t_band();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule